// File: doc/BRIEF.md
# Daisy-Chained Input Serializer Reader

This block is an SPI master that reads a chain of industrial digital-input serializer chips. Each chip in the chain supplies eight input bits. A one-cycle start pulse launches one frame. Chip select stays low for the whole frame, and the engine shifts in one byte per chip in 8-bit mode, or two bytes per chip in 16-bit mode (the input byte first, then a status byte). The chip nearest the master comes first in the stream.

When the frame ends, the block decodes each chip's status byte. It checks a 5-bit CRC of the input byte and decodes the overtemperature, undervoltage-alarm and undervoltage-warning bits. It also samples an external fault input, which is either shared by all chips or provided per chip. From all of these it forms a per-chip fault decision. The input vector, a per-chip valid mask and the diagnostic flags are then registered together, and a done pulse marks the update. A faulting chip is flagged invalid, and its neighbours stay valid.

The block also drives the chain's mode-select line and two debounce-select lines per debounce group. Each debounce group is either one per chip or a single shared group.

Top module: `serin_chain_reader`

## Requirements
- R1: A start pulse while idle drops cs_n_o for one uninterrupted frame. The frame has exactly N_CHIPS*8 rising sclk_o edges in 8-bit mode and N_CHIPS*16 in 16-bit mode. sclk_o idles low and is high only while cs_n_o is low (SPI mode 0).
- R2: The stream is received MSB first. Frame byte k goes to chip k in 8-bit mode. In 16-bit mode, byte 2k is chip k's input byte and byte 2k+1 is its status byte. Chip k's inputs appear on in_vec_o[8k+7:8k].
- R3: In 16-bit mode, status bits [7:3] must equal the 5-bit CRC of the input byte. The CRC uses generator x^5+x^4+x^2+1, is processed MSB first and starts from zero. A mismatch sets that chip's crc_err_o bit.
- R4: In 16-bit mode, status bit 1 high sets the chip's overtemp_o bit.
- R5: In 16-bit mode, status bit 2 low sets uv_alarm_o. Status bit 0 low sets uv_warn_o. The warning alone never clears the chip's valid bit.
- R6: A high fault input sets pin_fault_o for the chip it serves. With FAULT_PINS=1 one pin serves every chip; otherwise pin k serves chip k.
- R7: With ignore_uv_i high, uv_alarm_o, uv_warn_o and pin_fault_o stay 0, and none of those conditions makes a chip invalid.
- R8: In 8-bit mode the fault input is the only diagnostic. crc_err_o, overtemp_o, uv_alarm_o and uv_warn_o are 0.
- R9: valid_o[k] is 1 exactly when chip k has none of: CRC error, overtemperature, unmasked undervoltage alarm, unmasked fault input. Other chips are unaffected.
- R10: done_o is a one-cycle pulse after cs_n_o rises. The input vector, valid mask and flags change only in a done_o cycle.
- R11: A start pulse during a frame is ignored. It causes no second frame and no extra done_o.
- R12: modesel_o follows mode8_i (1 = 8-bit, 0 = 16-bit) one cycle later. The 2-bit code deb_code_i[2g+1:2g] is registered to group g as deb_a_o[g] = code bit 1 and deb_b_o[g] = code bit 0. The codes are 00 = none, 01 = up to 25 us, 10 = up to 750 us, 11 = up to 3000 us.
- R13: After reset, cs_n_o=1, sclk_o=0, done_o=0, modesel_o=0, and the input vector, valid mask and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame launch pulse |
| mode8_i | input | 1 | 1 = 8-bit frames, 0 = 16-bit frames with status |
| ignore_uv_i | input | 1 | Mask undervoltage and the fault input |
| fault_pin_i | input | FAULT_PINS | Active-high fault input(s) |
| deb_code_i | input | 2*DEB_GROUPS | Debounce code per group |
| miso_i | input | 1 | Serial data from the chain |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_n_o | output | 1 | Chip select, active low |
| modesel_o | output | 1 | Mode-select line to the chips |
| deb_a_o | output | DEB_GROUPS | Debounce select, code bit 1 |
| deb_b_o | output | DEB_GROUPS | Debounce select, code bit 0 |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Results updated this cycle |
| in_vec_o | output | 8*N_CHIPS | Input bits, chip k at [8k+7:8k] |
| valid_o | output | N_CHIPS | Per-chip validity |
| crc_err_o | output | N_CHIPS | CRC mismatch flags |
| overtemp_o | output | N_CHIPS | Overtemperature flags |
| uv_alarm_o | output | N_CHIPS | Undervoltage alarm flags |
| uv_warn_o | output | N_CHIPS | Undervoltage warning flags |
| pin_fault_o | output | N_CHIPS | Fault input flags |

## Verification
Every cycle, the assertions check the following. sclk_o is high only inside a cs_n_o window. A frame begins only from an idle start. done_o is a single pulse following frame end, and results hold still outside it. No chip is marked valid while any of its fault flags is set. modesel_o tracks mode8_i. Only the bench scenarios can show the rest: the exact bit count per frame, the byte-to-chip mapping, the CRC arithmetic against hand-built status bytes, the masking by ignore_uv_i, the 8-bit mode reduction, and the debounce encoding.

// File: rtl/serin_pkg.sv
package serin_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic crc_err;
    logic overtemp;
    logic uv_alarm;
    logic uv_warn;
    logic pin_fault;
  } chip_diag_t;

  // 5-bit CRC, generator x^5+x^4+x^2+1, MSB first, zero seed (R3)
  function automatic logic [4:0] crc5_msb(input logic [7:0] d);
    logic [4:0] c;
    logic       fb;
    c = '0;
    for (int k = 7; k >= 0; k--) begin
      fb = c[4] ^ d[k];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b10101;
    end
    return c;
  endfunction

  // warning is deliberately left out of the fault decision (R5, R9)
  function automatic logic chip_faulting(input chip_diag_t d);
    return d.pin_fault | d.crc_err | d.overtemp | d.uv_alarm;
  endfunction
endpackage

// File: rtl/serin_spi_engine.sv
module serin_spi_engine #(
  parameter int N_CHIPS = 3,
  parameter int CLK_DIV = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic                               mode8_i,
  input  logic                               miso_i,
  output logic                               sclk_o,
  output logic                               cs_n_o,
  output logic                               busy_o,
  output logic                               byte_stb_o,
  output logic [7:0]                         byte_o,
  output logic [$clog2(2*N_CHIPS)-1:0]       byte_idx_o,
  output logic                               frame_end_o,
  output logic                               frame_mode8_o
);
  localparam int MAX_BITS = N_CHIPS * 16;
  localparam int BIT_W    = $clog2(MAX_BITS);
  localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIDX_W   = $clog2(2*N_CHIPS);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] last_q;
  logic [6:0]       sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o        <= 1'b0;
      cs_n_o        <= 1'b1;
      sclk_o        <= 1'b0;
      div_q         <= '0;
      bit_q         <= '0;
      last_q        <= '0;
      sh_q          <= '0;
      byte_stb_o    <= 1'b0;
      byte_o        <= '0;
      byte_idx_o    <= '0;
      frame_end_o   <= 1'b0;
      frame_mode8_o <= 1'b0;
    end else begin
      byte_stb_o  <= 1'b0;
      frame_end_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o        <= 1'b1;
          cs_n_o        <= 1'b0;
          div_q         <= '0;
          bit_q         <= '0;
          last_q        <= mode8_i ? BIT_W'(N_CHIPS*8 - 1) : BIT_W'(N_CHIPS*16 - 1);
          frame_mode8_o <= mode8_i;
        end
      end else if (div_q == DIV_W'(CLK_DIV - 1)) begin
        div_q <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          sh_q   <= {sh_q[5:0], miso_i};
          if (bit_q[2:0] == 3'd7) begin
            byte_stb_o <= 1'b1;
            byte_o     <= {sh_q, miso_i};
            byte_idx_o <= BIDX_W'(bit_q >> 3);
          end
        end else begin
          sclk_o <= 1'b0;
          if (bit_q == last_q) begin
            busy_o      <= 1'b0;
            cs_n_o      <= 1'b1;
            frame_end_o <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serin_chip_diag.sv
module serin_chip_diag
  import serin_pkg::*;
(
  input  logic [7:0]  in_byte_i,
  input  logic [7:0]  status_i,
  input  logic        mode8_i,
  input  logic        ignore_uv_i,
  input  logic        fault_pin_i,
  output chip_diag_t  diag_o,
  output logic        faulting_o
);
  always_comb begin
    diag_o.crc_err   = !mode8_i && (status_i[7:3] != crc5_msb(in_byte_i));
    diag_o.overtemp  = !mode8_i && status_i[1];
    diag_o.uv_alarm  = !mode8_i && !ignore_uv_i && !status_i[2];
    diag_o.uv_warn   = !mode8_i && !ignore_uv_i && !status_i[0];
    diag_o.pin_fault = !ignore_uv_i && fault_pin_i;
    faulting_o       = chip_faulting(diag_o);
  end
endmodule

// File: rtl/serin_chain_reader.sv
module serin_chain_reader
  import serin_pkg::*;
#(
  parameter int N_CHIPS    = 3,
  parameter int CLK_DIV    = 2,
  parameter int FAULT_PINS = 3,
  parameter int DEB_GROUPS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         mode8_i,
  input  logic                         ignore_uv_i,
  input  logic [FAULT_PINS-1:0]        fault_pin_i,
  input  logic [2*DEB_GROUPS-1:0]      deb_code_i,
  input  logic                         miso_i,
  output logic                         sclk_o,
  output logic                         cs_n_o,
  output logic                         modesel_o,
  output logic [DEB_GROUPS-1:0]        deb_a_o,
  output logic [DEB_GROUPS-1:0]        deb_b_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [BYTE_W*N_CHIPS-1:0]    in_vec_o,
  output logic [N_CHIPS-1:0]           valid_o,
  output logic [N_CHIPS-1:0]           crc_err_o,
  output logic [N_CHIPS-1:0]           overtemp_o,
  output logic [N_CHIPS-1:0]           uv_alarm_o,
  output logic [N_CHIPS-1:0]           uv_warn_o,
  output logic [N_CHIPS-1:0]           pin_fault_o
);
  localparam int NBYTES = 2 * N_CHIPS;
  localparam int BIDX_W = $clog2(NBYTES);

  // internal events named for the checker
  logic              byte_stb_w;
  logic [7:0]        byte_w;
  logic [BIDX_W-1:0] byte_idx_w;
  logic              frame_end_w;
  logic              frame_mode8_w;
  logic [N_CHIPS-1:0] faulting_w;
  chip_diag_t        diag_w [N_CHIPS];
  logic [7:0]        in_byte_w [N_CHIPS];
  logic [7:0]        rxbuf_q [NBYTES];

  serin_spi_engine #(.N_CHIPS(N_CHIPS), .CLK_DIV(CLK_DIV)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mode8_i       (mode8_i),
    .miso_i        (miso_i),
    .sclk_o        (sclk_o),
    .cs_n_o        (cs_n_o),
    .busy_o        (busy_o),
    .byte_stb_o    (byte_stb_w),
    .byte_o        (byte_w),
    .byte_idx_o    (byte_idx_w),
    .frame_end_o   (frame_end_w),
    .frame_mode8_o (frame_mode8_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBYTES; b++) rxbuf_q[b] <= '0;
    end else if (byte_stb_w) begin
      rxbuf_q[byte_idx_w] <= byte_w;
    end
  end

  for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
    localparam int FI = (FAULT_PINS == 1) ? 0 : c;
    assign in_byte_w[c] = frame_mode8_w ? rxbuf_q[c] : rxbuf_q[2*c];
    serin_chip_diag u_diag (
      .in_byte_i   (in_byte_w[c]),
      .status_i    (rxbuf_q[2*c+1]),
      .mode8_i     (frame_mode8_w),
      .ignore_uv_i (ignore_uv_i),
      .fault_pin_i (fault_pin_i[FI]),
      .diag_o      (diag_w[c]),
      .faulting_o  (faulting_w[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      in_vec_o    <= '0;
      valid_o     <= '0;
      crc_err_o   <= '0;
      overtemp_o  <= '0;
      uv_alarm_o  <= '0;
      uv_warn_o   <= '0;
      pin_fault_o <= '0;
    end else begin
      done_o <= frame_end_w;
      if (frame_end_w) begin
        for (int c = 0; c < N_CHIPS; c++) begin
          in_vec_o[BYTE_W*c +: BYTE_W] <= in_byte_w[c];
          valid_o[c]     <= !faulting_w[c];
          crc_err_o[c]   <= diag_w[c].crc_err;
          overtemp_o[c]  <= diag_w[c].overtemp;
          uv_alarm_o[c]  <= diag_w[c].uv_alarm;
          uv_warn_o[c]   <= diag_w[c].uv_warn;
          pin_fault_o[c] <= diag_w[c].pin_fault;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modesel_o <= 1'b0;
    else        modesel_o <= mode8_i;
  end

  for (genvar g = 0; g < DEB_GROUPS; g++) begin : g_deb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        deb_a_o[g] <= 1'b0;
        deb_b_o[g] <= 1'b0;
      end else begin
        deb_a_o[g] <= deb_code_i[2*g+1];
        deb_b_o[g] <= deb_code_i[2*g];
      end
    end
  end
endmodule

// File: rtl/serin_chain_checker.sv
module serin_chain_checker #(
  parameter int N_CHIPS = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    mode8_i,
  input logic                    sclk_o,
  input logic                    cs_n_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    modesel_o,
  input logic [8*N_CHIPS-1:0]    in_vec_o,
  input logic [N_CHIPS-1:0]      valid_o,
  input logic [N_CHIPS-1:0]      crc_err_o,
  input logic [N_CHIPS-1:0]      overtemp_o,
  input logic [N_CHIPS-1:0]      uv_alarm_o,
  input logic [N_CHIPS-1:0]      pin_fault_o,
  input logic                    frame_end_w,
  input logic [N_CHIPS-1:0]      faulting_w
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_sclk_inside_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && !sclk_o));

  assert_frame_from_idle_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $fell(cs_n_o)) |-> ($past(start_i) && !$past(busy_o)));

  assert_valid_excludes_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o & (crc_err_o | overtemp_o | uv_alarm_o | pin_fault_o)) == '0);

  assert_valid_tracks_decision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && done_o) |-> (valid_o == ~$past(faulting_w)));

  assert_done_after_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && done_o) |-> ($past(frame_end_w) && cs_n_o));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_outside_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !done_o) |-> ($stable(valid_o) && $stable(in_vec_o)));

  assert_modesel_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (modesel_o == $past(mode8_i)));
endmodule

bind serin_chain_reader serin_chain_checker #(.N_CHIPS(N_CHIPS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mode8_i     (mode8_i),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .modesel_o   (modesel_o),
  .in_vec_o    (in_vec_o),
  .valid_o     (valid_o),
  .crc_err_o   (crc_err_o),
  .overtemp_o  (overtemp_o),
  .uv_alarm_o  (uv_alarm_o),
  .pin_fault_o (pin_fault_o),
  .frame_end_w (frame_end_w),
  .faulting_w  (faulting_w)
);

// File: tb/tb_serin_chain_reader.sv
`timescale 1ns/1ps
module tb_serin_chain_reader;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode8_i = 1'b0, ignore_uv_i = 1'b0;
  logic [N-1:0] fault_pin_i = '0;
  logic [2*N-1:0] deb_code_i = '0;
  logic miso_i;
  logic sclk_o, cs_n_o, modesel_o, busy_o, done_o;
  logic [N-1:0] deb_a_o, deb_b_o, valid_o, crc_err_o, overtemp_o, uv_alarm_o, uv_warn_o, pin_fault_o;
  logic [8*N-1:0] in_vec_o;

  always #2.5 clk = ~clk;

  serin_chain_reader #(.N_CHIPS(N), .CLK_DIV(2), .FAULT_PINS(N), .DEB_GROUPS(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode8_i(mode8_i),
    .ignore_uv_i(ignore_uv_i), .fault_pin_i(fault_pin_i), .deb_code_i(deb_code_i),
    .miso_i(miso_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .modesel_o(modesel_o),
    .deb_a_o(deb_a_o), .deb_b_o(deb_b_o), .busy_o(busy_o), .done_o(done_o),
    .in_vec_o(in_vec_o), .valid_o(valid_o), .crc_err_o(crc_err_o),
    .overtemp_o(overtemp_o), .uv_alarm_o(uv_alarm_o), .uv_warn_o(uv_warn_o),
    .pin_fault_o(pin_fault_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  int rise_total = 0, fall_total = 0, fall_base = 0, cs_rise_total = 0, done_total = 0;
  int nbytes = 0;
  logic [7:0] tx [2*N];

  // chain model: one bit per falling sclk edge, first bit ready at cs_n fall
  always @(posedge sclk_o) rise_total++;
  always @(negedge sclk_o) fall_total++;
  always @(negedge cs_n_o) fall_base = fall_total;
  always @(posedge cs_n_o) cs_rise_total++;
  always @(posedge clk) if (done_o) done_total++;

  always_comb begin
    int p;
    p = fall_total - fall_base;
    if (p < nbytes*8) miso_i = tx[p/8][7 - (p%8)];
    else              miso_i = 1'b0;
  end

  task automatic summary_and_end();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      summary_and_end();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // byte-wise CRC using the generator aligned to the top of an 8-bit register
  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [7:0] r;
    r = d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'hA8) : (r << 1);
    return r[7:3];
  endfunction

  // kind: 0 healthy, 1 bad CRC, 2 overtemperature, 3 undervoltage alarm, 4 undervoltage warning
  function automatic logic [7:0] make_status(input logic [7:0] d, input logic [2:0] k);
    logic [7:0] s;
    s = {ref_crc(d), 3'b101};
    if (k == 3'd1) s[7] = ~s[7];
    if (k == 3'd2) s[1] = 1'b1;
    if (k == 3'd3) s[2] = 1'b0;
    if (k == 3'd4) s[0] = 1'b0;
    return s;
  endfunction

  typedef struct packed {
    logic m8; logic ig; logic [N-1:0] fp; logic [8*N-1:0] din; logic [3*N-1:0] kind;
  } vec_t;

  localparam vec_t VECS [9] = '{
    {1'b0, 1'b0, 3'b000, 24'h5A3C81, 9'o000},  // all healthy
    {1'b0, 1'b0, 3'b000, 24'h12FF7E, 9'o010},  // CRC error on chip 1
    {1'b0, 1'b0, 3'b000, 24'hC3A501, 9'o302},  // overtemp chip 0, uv alarm chip 2
    {1'b0, 1'b0, 3'b000, 24'h0055AA, 9'o040},  // uv warning only, chip 1
    {1'b0, 1'b0, 3'b100, 24'h8001FE, 9'o000},  // fault pin chip 2
    {1'b0, 1'b1, 3'b100, 24'h6B29D4, 9'o043},  // ignore uv masks alarm, warn, pin
    {1'b1, 1'b0, 3'b010, 24'hF00F33, 9'o121},  // 8-bit, fault pin chip 1
    {1'b1, 1'b1, 3'b111, 24'h9E4C17, 9'o000},  // 8-bit, pins ignored
    {1'b0, 1'b0, 3'b111, 24'h000000, 9'o111}   // everything faulting
  };

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int w = 0; w < 4000; w++) begin
      @(negedge clk);
      if (done_o) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [N-1:0] e_crc, e_ot, e_uva, e_uvw, e_pf, e_vld;
    int r0;
    bit seen;
    @(negedge clk);
    mode8_i = v.m8; ignore_uv_i = v.ig; fault_pin_i = v.fp;
    nbytes = v.m8 ? N : 2*N;
    for (int c = 0; c < N; c++) begin
      logic [7:0] d;
      logic [2:0] k;
      d = v.din[8*c +: 8];
      k = v.kind[3*c +: 3];
      if (v.m8) tx[c] = d;
      else begin tx[2*c] = d; tx[2*c+1] = make_status(d, k); end
      e_crc[c] = !v.m8 && (k == 3'd1);
      e_ot[c]  = !v.m8 && (k == 3'd2);
      e_uva[c] = !v.m8 && !v.ig && (k == 3'd3);
      e_uvw[c] = !v.m8 && !v.ig && (k == 3'd4);
      e_pf[c]  = !v.ig && v.fp[c];
      e_vld[c] = !(e_crc[c] | e_ot[c] | e_uva[c] | e_pf[c]);
    end
    r0 = rise_total;
    pulse_start();
    wait_done(seen);
    chk("R10 done seen", 64'(seen), 64'd1);
    chk("R1 sclk edges per frame", 64'(rise_total - r0), 64'(v.m8 ? 8*N : 16*N));
    chk("R2 input vector", 64'(in_vec_o), 64'(v.din));
    chk("R3 crc_err", 64'(crc_err_o), 64'(e_crc));
    chk("R4 overtemp", 64'(overtemp_o), 64'(e_ot));
    chk("R5 uv_alarm", 64'(uv_alarm_o), 64'(e_uva));
    chk("R5 uv_warn", 64'(uv_warn_o), 64'(e_uvw));
    chk(v.ig ? "R7 pin_fault masked" : "R6 pin_fault", 64'(pin_fault_o), 64'(e_pf));
    chk(v.m8 ? "R8 valid 8-bit" : "R9 valid mask", 64'(valid_o), 64'(e_vld));
    @(negedge clk);
    chk("R10 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    int d0, c0, r0;
    bit seen;
    repeat (3) @(negedge clk);
    // R13 reset values while reset is held
    chk("R13 cs_n", 64'(cs_n_o), 64'd1);
    chk("R13 sclk", 64'(sclk_o), 64'd0);
    chk("R13 done", 64'(done_o), 64'd0);
    chk("R13 modesel", 64'(modesel_o), 64'd0);
    chk("R13 valid/in_vec", 64'({valid_o, in_vec_o}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 9; i++) run_vec(VECS[i]);

    // R12 mode-select and debounce encoding
    @(negedge clk);
    mode8_i = 1'b1; deb_code_i = 6'b11_10_01;
    @(negedge clk);
    chk("R12 modesel 8-bit", 64'(modesel_o), 64'd1);
    chk("R12 deb_a", 64'(deb_a_o), 64'(3'b110));
    chk("R12 deb_b", 64'(deb_b_o), 64'(3'b101));
    mode8_i = 1'b0; deb_code_i = 6'b00_01_10;
    @(negedge clk);
    chk("R12 modesel 16-bit", 64'(modesel_o), 64'd0);
    chk("R12 deb_a shared change", 64'({deb_a_o, deb_b_o}), 64'({3'b001, 3'b010}));

    // R11 start during a frame is ignored
    nbytes = 2*N;
    for (int c = 0; c < N; c++) begin
      tx[2*c] = 8'(8'h11 * (c + 1));
      tx[2*c+1] = make_status(8'(8'h11 * (c + 1)), 3'd0);
    end
    fault_pin_i = '0; ignore_uv_i = 1'b0;
    d0 = done_total; c0 = cs_rise_total; r0 = rise_total;
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_done(seen);
    repeat (400) @(negedge clk);
    chk("R11 single done", 64'(done_total - d0), 64'd1);
    chk("R11 single cs window", 64'(cs_rise_total - c0), 64'd1);
    chk("R11 edge count", 64'(rise_total - r0), 64'(16*N));
    chk("R11 data intact", 64'(in_vec_o), 64'(24'h332211));

    summary_and_end();
  end
endmodule